// File: doc/BRIEF.md
# Power-On Strap Capture and Frequency Code Selection

This block sits between the shared strap/clock pads of a clock synthesizer and its frequency logic. While the power-on window is open, several pads act as inputs whose resistor-set levels are recorded every cycle. When the window closes, the recorded levels are frozen and the same pads are handed over to the clock drivers through per-pad output enables.

The frozen straps give the frequency select code, a desktop/mobile mode flag and a CPU buffer-voltage flag. A configuration override bit decides whether the frequency code comes from the frozen straps or from a three-bit register field. The chosen code is registered, translated into nominal CPU and PCI rates in kHz, and any later change of the code raises a single-cycle pulse for the synthesizer. The mode flag decides whether two further shared pads carry clocks (desktop) or act as active-low stop requests (mobile). Whenever a stop pad is not an input, the stop signal handed downstream reads inactive.

Top module: `strap_fsel_ctrl`

## Requirements
- R1: While `rst_n` is low, `strap_oe_o` and `shared_oe_o` are all zero, `freq_code_o` is 000, `freq_chg_o` is 0, `desktop_mode_o` and `cpu_vlow_o` are 0.
- R2: While `por_i` is high, `strap_oe_o` is all zero. At the first rising edge that samples `por_i` low, all five bits of `strap_oe_o` go to 1.
- R3: The strap levels are taken from `strap_pad_i` at every edge that samples `por_i` high and are held at every edge that samples it low; pad activity after the window has no effect on code, mode or voltage flag.
- R4: Field layout of `strap_pad_i`: bits [2:0] are the frequency strap code (bit 2 most significant), bit 3 is the mode strap, bit 4 is the buffer-voltage strap.
- R5: Field layout of `cfg_i`: bit 0 is the override; bits [3:1] are the register frequency code. With bit 0 at 0 the selected code is the held strap code; with bit 0 at 1 it is `cfg_i[3:1]`. `freq_code_o` shows the selection one clock later.
- R6: `cpu_khz_o`/`pci_khz_o` follow `freq_code_o` with these rates: 000 50000/25000, 001 75000/32000, 010 83300/41650, 011 68500/34250, 100 83300/33300, 101 75000/37500, 110 60000/30000, 111 66800/33400.
- R7: `desktop_mode_o` equals the held mode strap; `shared_oe_o` is 11 only when the window is closed and the mode is 1 (desktop), else 00.
- R8: `cpu_stop_n_o` and `pci_stop_n_o` are 1 while the window is open or in desktop mode; in mobile mode after the window they follow `stop_pad_i[0]` and `stop_pad_i[1]` respectively.
- R9: `freq_chg_o` is high for exactly the cycle in which `freq_code_o` takes a new value after the window has closed; it stays low for updates made while the window is open or at the edge that closes it.
- R10: `cpu_vlow_o` equals the held buffer-voltage strap (1 selects the 2.5 V buffer, 0 the 3.3 V buffer).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | High while the power-on strap window is open |
| strap_pad_i | input | 5 | Raw levels on the strap/clock shared pads |
| stop_pad_i | input | 2 | Raw levels on the mode-shared pads ([0] CPU stop, [1] PCI stop) |
| cfg_i | input | 4 | Override bit [0] and register frequency code [3:1] |
| strap_oe_o | output | 5 | Output-drive enable per strap pad |
| shared_oe_o | output | 2 | Output-drive enable for the two mode-shared pads |
| freq_code_o | output | 3 | Active frequency select code |
| freq_chg_o | output | 1 | One-cycle pulse on a code change |
| cpu_khz_o | output | 17 | Nominal CPU clock rate in kHz |
| pci_khz_o | output | 17 | Nominal PCI clock rate in kHz |
| desktop_mode_o | output | 1 | 1 desktop, 0 mobile |
| cpu_vlow_o | output | 1 | 1 selects 2.5 V CPU buffers |
| cpu_stop_n_o | output | 1 | Active-low CPU stop request to downstream logic |
| pci_stop_n_o | output | 1 | Active-low PCI stop request to downstream logic |

## Verification
The assertions assume `por_i`, `strap_pad_i`, `stop_pad_i` and `cfg_i` are already synchronous to `clk`, that the power-on window is opened after reset rather than overlapping a mid-run reset edge, and that the stop pads are only meaningful once the window has closed. The stimulus changes every input only one time unit after a rising edge, opens each window with `por_i` held high for at least two edges, and drives stop-pad levels only after the window is closed, so every property sees clean, edge-aligned inputs.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int FS_W    = 3;
  localparam int KHZ_W   = 17;
  localparam int N_SHARE = 2;

  // Packed order matches the pad vector: [4] voltage, [3] mode, [2:0] code
  typedef struct packed {
    logic            vlow;
    logic            desktop;
    logic [FS_W-1:0] fs;
  } strap_t;

  localparam int N_STRAP = $bits(strap_t);

  function automatic logic [KHZ_W-1:0] cpu_rate(input logic [FS_W-1:0] c);
    logic [KHZ_W-1:0] r;
    case (c)
      3'd0:    r = KHZ_W'(50000);
      3'd1:    r = KHZ_W'(75000);
      3'd2:    r = KHZ_W'(83300);
      3'd3:    r = KHZ_W'(68500);
      3'd4:    r = KHZ_W'(83300);
      3'd5:    r = KHZ_W'(75000);
      3'd6:    r = KHZ_W'(60000);
      default: r = KHZ_W'(66800);
    endcase
    return r;
  endfunction

  // Most codes run PCI at half the CPU rate; two codes use fixed rates
  function automatic logic [KHZ_W-1:0] pci_rate(input logic [FS_W-1:0] c);
    logic [KHZ_W-1:0] r;
    case (c)
      3'd1:    r = KHZ_W'(32000);
      3'd4:    r = KHZ_W'(33300);
      default: r = cpu_rate(c) >> 1;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   por_i,
  input  strap_t pad_i,
  output strap_t held_o,
  output logic   done_o
);
  strap_t held_q, held_d;
  logic   done_q, done_d;

  always_comb begin
    held_d = held_q;
    if (por_i) held_d = pad_i;
    done_d = ~por_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      done_q <= 1'b0;
    end else begin
      held_q <= held_d;
      done_q <= done_d;
    end
  end

  assign held_o = held_q;
  assign done_o = done_q;

  // R3
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !por_i |=> $stable(held_q));
  // R2
  oe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> !done_q);
endmodule

// File: rtl/fsel_mux.sv
module fsel_mux
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic [FS_W-1:0]  fs_strap_i,
  input  logic             ovr_i,
  input  logic [FS_W-1:0]  fs_reg_i,
  output logic [FS_W-1:0]  code_o,
  output logic             chg_o,
  output logic [KHZ_W-1:0] cpu_khz_o,
  output logic [KHZ_W-1:0] pci_khz_o
);
  logic [FS_W-1:0]  sel;
  logic [FS_W-1:0]  code_q, code_d;
  logic             chg_q, chg_d;
  logic [KHZ_W-1:0] cpu_q, cpu_d, pci_q, pci_d;

  always_comb begin
    sel    = ovr_i ? fs_reg_i : fs_strap_i;
    code_d = sel;
    chg_d  = done_i && (sel != code_q);
    cpu_d  = cpu_rate(sel);
    pci_d  = pci_rate(sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      chg_q  <= 1'b0;
      cpu_q  <= cpu_rate('0);
      pci_q  <= pci_rate('0);
    end else begin
      code_q <= code_d;
      chg_q  <= chg_d;
      cpu_q  <= cpu_d;
      pci_q  <= pci_d;
    end
  end

  assign code_o    = code_q;
  assign chg_o     = chg_q;
  assign cpu_khz_o = cpu_q;
  assign pci_khz_o = pci_q;

  // R9
  pulse_on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg_q |-> (code_q != $past(code_q)));
  // R9
  quiet_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_i |=> !chg_q);
  // R5
  override_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_i |=> (code_q == $past(fs_reg_i)));
endmodule

// File: rtl/shared_pin_ctrl.sv
module shared_pin_ctrl
  import strap_pkg::*;
#(
  parameter int NS = N_STRAP,
  parameter int NM = N_SHARE
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic          desktop_i,
  input  logic [NM-1:0] stop_pad_i,
  output logic [NS-1:0] strap_oe_o,
  output logic [NM-1:0] shared_oe_o,
  output logic [NM-1:0] stop_n_o
);
  logic pads_are_outputs;

  always_comb begin
    pads_are_outputs = done_i & desktop_i;
    strap_oe_o       = {NS{done_i}};
    shared_oe_o      = {NM{pads_are_outputs}};
  end

  for (genvar g = 0; g < NM; g++) begin : g_stop
    assign stop_n_o[g] = (done_i && !desktop_i) ? stop_pad_i[g] : 1'b1;
  end

  // R8
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_i || desktop_i) |-> (&stop_n_o));
  // R7
  shared_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|shared_oe_o) |-> (desktop_i && (&strap_oe_o)));
endmodule

// File: rtl/strap_fsel_ctrl.sv
module strap_fsel_ctrl
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             por_i,
  input  logic [4:0]       strap_pad_i,
  input  logic [1:0]       stop_pad_i,
  input  logic [3:0]       cfg_i,
  output logic [4:0]       strap_oe_o,
  output logic [1:0]       shared_oe_o,
  output logic [2:0]       freq_code_o,
  output logic             freq_chg_o,
  output logic [16:0]      cpu_khz_o,
  output logic [16:0]      pci_khz_o,
  output logic             desktop_mode_o,
  output logic             cpu_vlow_o,
  output logic             cpu_stop_n_o,
  output logic             pci_stop_n_o
);
  strap_t      pad_s;
  strap_t      held;
  logic        done;
  logic [1:0]  stop_n;

  assign pad_s = strap_t'(strap_pad_i);

  strap_capture u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .por_i  (por_i),
    .pad_i  (pad_s),
    .held_o (held),
    .done_o (done)
  );

  fsel_mux u_fsel (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (done),
    .fs_strap_i (held.fs),
    .ovr_i      (cfg_i[0]),
    .fs_reg_i   (cfg_i[3:1]),
    .code_o     (freq_code_o),
    .chg_o      (freq_chg_o),
    .cpu_khz_o  (cpu_khz_o),
    .pci_khz_o  (pci_khz_o)
  );

  shared_pin_ctrl #(.NS(N_STRAP), .NM(N_SHARE)) u_pins (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (done),
    .desktop_i   (held.desktop),
    .stop_pad_i  (stop_pad_i),
    .strap_oe_o  (strap_oe_o),
    .shared_oe_o (shared_oe_o),
    .stop_n_o    (stop_n)
  );

  assign desktop_mode_o = held.desktop;
  assign cpu_vlow_o     = held.vlow;
  assign cpu_stop_n_o   = stop_n[0];
  assign pci_stop_n_o   = stop_n[1];

  // R10
  vlow_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_i && !$past(por_i)) |=> $stable(cpu_vlow_o));
endmodule

// File: tb/strap_fsel_ctrl_tb.sv
module strap_fsel_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        por_i;
  logic [4:0]  strap_pad_i;
  logic [1:0]  stop_pad_i;
  logic [3:0]  cfg_i;
  logic [4:0]  strap_oe_o;
  logic [1:0]  shared_oe_o;
  logic [2:0]  freq_code_o;
  logic        freq_chg_o;
  logic [16:0] cpu_khz_o, pci_khz_o;
  logic        desktop_mode_o, cpu_vlow_o, cpu_stop_n_o, pci_stop_n_o;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  strap_fsel_ctrl dut_i (.*);

  // {strap[4:0], cfg[3:0], expected code[2:0]}
  localparam int NV = 8;
  localparam logic [11:0] VEC [NV] = '{
    {5'b00000, 4'b0000, 3'b000},
    {5'b01001, 4'b0000, 3'b001},
    {5'b10010, 4'b0000, 3'b010},
    {5'b00011, 4'b1111, 3'b111},
    {5'b11100, 4'b0000, 3'b100},
    {5'b00101, 4'b0001, 3'b000},
    {5'b01110, 4'b0111, 3'b011},
    {5'b10111, 4'b1010, 3'b111}
  };

  function automatic int exp_cpu(input logic [2:0] c);
    case (c)
      3'd0: return 50000; 3'd1: return 75000; 3'd2: return 83300;
      3'd3: return 68500; 3'd4: return 83300; 3'd5: return 75000;
      3'd6: return 60000; default: return 66800;
    endcase
  endfunction
  function automatic int exp_pci(input logic [2:0] c);
    case (c)
      3'd0: return 25000; 3'd1: return 32000; 3'd2: return 41650;
      3'd3: return 34250; 3'd4: return 33300; 3'd5: return 37500;
      3'd6: return 30000; default: return 33400;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic run_window(input logic [4:0] s);
    por_i = 1'b1;
    strap_pad_i = s;
    step(2);
    por_i = 1'b0;
    step(1);
  endtask

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    if (!done_flag) $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; por_i = 1'b1; strap_pad_i = 5'b11111;
    stop_pad_i = 2'b00; cfg_i = 4'b0000;
    step(3);
    // R1 reset state
    check("R1 strap_oe", strap_oe_o, 0);
    check("R1 shared_oe", shared_oe_o, 0);
    check("R1 code", freq_code_o, 0);
    check("R1 chg", freq_chg_o, 0);
    check("R1 mode/vlow", {desktop_mode_o, cpu_vlow_o}, 0);
    rst_n = 1'b1;
    step(2);
    // R2 window open: no drive; R8 stops inactive in window
    check("R2 oe in window", strap_oe_o, 0);
    check("R8 stops in window", {cpu_stop_n_o, pci_stop_n_o}, 3);
    check("R9 no pulse in window", freq_chg_o, 0);

    // Vector walk: R4 R5 R6 R7 R10
    for (int v = 0; v < NV; v++) begin
      logic [4:0] s;
      logic [2:0] ec;
      s  = VEC[v][11:7];
      ec = VEC[v][2:0];
      cfg_i = 4'b0000;
      run_window(s);
      check("R2 oe after window", strap_oe_o, 31);
      cfg_i = VEC[v][6:3];
      step(1);
      check("R5 code", freq_code_o, ec);
      check("R6 cpu rate", cpu_khz_o, exp_cpu(ec));
      check("R6 pci rate", pci_khz_o, exp_pci(ec));
      check("R7 mode", desktop_mode_o, s[3]);
      check("R7 shared oe", shared_oe_o, s[3] ? 3 : 0);
      check("R10 vlow", cpu_vlow_o, s[4]);
    end

    // R3 pads ignored after window
    cfg_i = 4'b0000;
    run_window(5'b01010);
    strap_pad_i = 5'b10101;
    step(3);
    check("R3 code held", freq_code_o, 2);
    check("R3 mode held", desktop_mode_o, 1);
    check("R3 vlow held", cpu_vlow_o, 0);

    // R8 desktop: stops inactive despite low pads
    stop_pad_i = 2'b00;
    #1;
    check("R8 desktop stops", {cpu_stop_n_o, pci_stop_n_o}, 3);

    // R8 mobile: stops follow pads
    run_window(5'b00110);
    stop_pad_i = 2'b10;
    #1;
    check("R8 cpu stop follows", cpu_stop_n_o, 0);
    check("R8 pci stop follows", pci_stop_n_o, 1);
    stop_pad_i = 2'b01;
    #1;
    check("R8 cpu stop follows 2", cpu_stop_n_o, 1);
    check("R8 pci stop follows 2", pci_stop_n_o, 0);

    // R9 pulse on change after window
    step(2);
    check("R9 steady no pulse", freq_chg_o, 0);
    cfg_i = 4'b0011;
    step(1);
    check("R9 pulse", freq_chg_o, 1);
    check("R9 new code", freq_code_o, 1);
    step(1);
    check("R9 pulse ends", freq_chg_o, 0);
    cfg_i = 4'b0010;
    step(1);
    check("R9 back to strap pulse", freq_chg_o, 1);
    check("R9 strap code", freq_code_o, 6);

    // R9 no pulse at window close even if code differs
    cfg_i = 4'b0000;
    por_i = 1'b1;
    strap_pad_i = 5'b00001;
    step(2);
    check("R9 no pulse in reopened window", freq_chg_o, 0);
    por_i = 1'b0;
    step(1);
    check("R9 no pulse at close", freq_chg_o, 0);
    check("R9 code at close", freq_code_o, 1);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule